// File: doc/BRIEF.md
# Bresenham Line Plotter for a Bit-Packed Monochrome Framebuffer

This block draws into a monochrome framebuffer of 648 by 256 pixels held in a byte-wide memory, one bit per pixel and eight pixels per byte with the leftmost pixel in the most significant bit. A host hands it one command at a time over a valid/ready handshake. A command either lights a single pixel or draws a straight line between two end points. Lines use the integer error-term stepping of Bresenham and work in every direction: horizontal, vertical, shallow, steep and exact diagonals.

Every lit pixel is a read-modify-write of the byte that holds it. The block reads the byte, ORs in the pixel's mask and writes the byte back on the next cycle. There is at most one memory access per cycle, and the memory returns read data one cycle after the read strobe. Points that fall off the screen produce no memory access, and the walk goes on to the next point. The block shows a busy level for the whole of a command and a one-cycle done pulse when the command ends.

Top module: `line_plotter`

## Requirements
- R1: While reset is held and after it is released, cmd_ready is 1, busy is 0, done is 0, and mem_re and mem_we are 0 until a command is accepted.
- R2: A command with cmd_line = 0 lights only the pixel at (cmd_x0, cmd_y0). cmd_x1 and cmd_y1 have no effect on what is written, and the other bits of the byte keep their values.
- R3: Pixel (x, y) sits in the byte at address y*81 + (x>>3), under mask 0x80 >> (x mod 8). For example, (647, 255) is byte 20735 with mask 0x01.
- R4: A command with cmd_line = 1 lights both end points and every point of the walk. The walk starts at (x0, y0) with dx = |x1-x0|, dy = |y1-y0| and err = dx-dy. After each point that is not (x1, y1), it takes e2 = 2*err. If e2 >= -dy, then err -= dy and x moves one step toward x1. If e2 <= dx, then err += dx and y moves one step toward y1.
- R5: Lines are drawn correctly in all eight octants, including reversed end points, single-point lines and 45-degree diagonals.
- R6: Each on-screen point takes one read cycle followed by one write cycle to the same address. The write data is the byte that was read ORed with the pixel mask. mem_re and mem_we are never high in the same cycle.
- R7: A point with x >= 648 or y >= 256 causes no memory access. The walk continues, and the on-screen points of the same line are still written.
- R8: busy is 1 from the cycle after a command is accepted until the cycle after the last write. cmd_ready is 0 for that whole time, and a command presented while busy is not taken.
- R9: done is 1 for exactly one cycle, the first cycle after busy falls.
- R10: A command keeps busy high for exactly 2 cycles per on-screen point plus 1 cycle per off-screen point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_line | input | 1 | 1 = draw line, 0 = set single pixel |
| cmd_x0 | input | 11 | Start x |
| cmd_y0 | input | 11 | Start y |
| cmd_x1 | input | 11 | End x (used for lines only) |
| cmd_y1 | input | 11 | End y (used for lines only) |
| mem_addr | output | 15 | Byte address |
| mem_re | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command ends |

## Verification
Two things can meet in one cycle: the write-back of a walk's last pixel and a new command held on cmd_valid. The bench provokes this by keeping cmd_valid high, with different coordinates, through every busy cycle, the last one included. It then checks that cmd_ready stayed low and that memory holds only the first command's pixels. A second overlap is a read of a byte in the cycle right after that same byte was written, which happens when neighbouring pixels share a byte. Horizontal lines and random shallow lines make this happen constantly, and a full compare of memory after every command shows whether any update was lost.

// File: rtl/lp_pkg.sv
package lp_pkg;
  // Controller phases: idle, present/skip a point, write back a byte
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLOT  = 2'd1,
    ST_WRITE = 2'd2
  } lp_state_e;
endpackage

// File: rtl/lp_addr_map.sv
module lp_addr_map #(
  parameter int SCR_W = 648,
  parameter int SCR_H = 256,
  parameter int CW    = 11,
  parameter int AW    = 15
) (
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  output logic [AW-1:0] addr,
  output logic [7:0]    mask,
  output logic          in_screen
);
  localparam int ROW_BYTES = SCR_W / 8;
  localparam int PW        = CW + $clog2(ROW_BYTES) + 1;

  logic [PW-1:0] lin;

  always_comb begin
    in_screen = (px < CW'(SCR_W)) && (py < CW'(SCR_H));
    lin       = PW'(py) * PW'(ROW_BYTES) + PW'(px >> 3);
    addr      = lin[AW-1:0];
    mask      = 8'h80 >> px[2:0];
  end

  // R3: an on-screen pixel always maps inside the framebuffer
  always_comb begin
    if (in_screen) begin
      a_addr_range_r3: assert (lin < PW'(ROW_BYTES * SCR_H));
    end
  end
endmodule

// File: rtl/lp_stepper.sv
module lp_stepper #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] ld_x0,
  input  logic [CW-1:0] ld_y0,
  input  logic [CW-1:0] ld_x1,
  input  logic [CW-1:0] ld_y1,
  output logic [CW-1:0] cur_x,
  output logic [CW-1:0] cur_y,
  output logic          at_end
);
  localparam int ERR_W = CW + 4;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] x_q, y_q, xe_q, ye_q, dx_q, dy_q;
  logic [CW-1:0] x_d, y_d, xe_d, ye_d, dx_d, dy_d;
  logic          sxn_q, syn_q, sxn_d, syn_d;
  logic signed [ERR_W-1:0] err_q, err_d;
  logic signed [ERR_W-1:0] e2, dxs, dys, acc;
  logic          en;

  assign en = load | step;

  // next-state
  always_comb begin
    x_d   = x_q;   y_d   = y_q;
    xe_d  = xe_q;  ye_d  = ye_q;
    dx_d  = dx_q;  dy_d  = dy_q;
    sxn_d = sxn_q; syn_d = syn_q;
    err_d = err_q;
    dxs   = signed'({{(ERR_W-CW){1'b0}}, dx_q});
    dys   = signed'({{(ERR_W-CW){1'b0}}, dy_q});
    e2    = err_q <<< 1;
    acc   = err_q;
    if (load) begin
      x_d   = ld_x0;
      y_d   = ld_y0;
      xe_d  = ld_x1;
      ye_d  = ld_y1;
      sxn_d = ld_x1 < ld_x0;
      syn_d = ld_y1 < ld_y0;
      dx_d  = sxn_d ? (ld_x0 - ld_x1) : (ld_x1 - ld_x0);
      dy_d  = syn_d ? (ld_y0 - ld_y1) : (ld_y1 - ld_y0);
      err_d = signed'({{(ERR_W-CW){1'b0}}, dx_d}) - signed'({{(ERR_W-CW){1'b0}}, dy_d});
    end else if (step) begin
      if (e2 >= -dys) begin
        acc = acc - dys;
        x_d = sxn_q ? (x_q - ONE) : (x_q + ONE);
      end
      if (e2 <= dxs) begin
        acc = acc + dxs;
        y_d = syn_q ? (y_q - ONE) : (y_q + ONE);
      end
      err_d = acc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; xe_q <= '0; ye_q <= '0;
      dx_q <= '0; dy_q <= '0; sxn_q <= 1'b0; syn_q <= 1'b0;
      err_q <= '0;
    end else if (en) begin
      x_q <= x_d; y_q <= y_d; xe_q <= xe_d; ye_q <= ye_d;
      dx_q <= dx_d; dy_q <= dy_d; sxn_q <= sxn_d; syn_q <= syn_d;
      err_q <= err_d;
    end
  end

  assign cur_x  = x_q;
  assign cur_y  = y_q;
  assign at_end = (x_q == xe_q) && (y_q == ye_q);

  // R4: the walk never advances past its end point
  p_no_step_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_end);
  // R4: every step moves the point
  p_step_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((x_q != $past(x_q)) || (y_q != $past(y_q))));
  // R5: a step changes each axis by at most one
  p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((x_q - $past(x_q) == ONE) || ($past(x_q) - x_q == ONE) || (x_q == $past(x_q))) &&
             ((y_q - $past(y_q) == ONE) || ($past(y_q) - y_q == ONE) || (y_q == $past(y_q))));
endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic in_screen,
  input  logic at_end,
  output logic cmd_ready,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic mem_re,
  output logic mem_we
);
  lp_state_e state_q, state_d;
  logic      finish, done_q;

  // next-state
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    mem_re  = 1'b0;
    mem_we  = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load    = 1'b1;
          state_d = ST_PLOT;
        end
      end
      ST_PLOT: begin
        if (in_screen) begin
          mem_re  = 1'b1;
          state_d = ST_WRITE;
        end else if (at_end) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step    = 1'b1;
        end
      end
      ST_WRITE: begin
        mem_we = 1'b1;
        if (at_end) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          step    = 1'b1;
          state_d = ST_PLOT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  // R6: every write is preceded by a read in the previous cycle
  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));
  // R6: every read is followed by its write-back
  p_read_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);
  // R8: an accepted command makes the block busy
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  // R9: done is a single-cycle pulse right after busy ends
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/line_plotter.sv
module line_plotter #(
  parameter int SCR_W = 648,
  parameter int SCR_H = 256,
  parameter int CW    = 11,
  parameter int AW    = $clog2((SCR_W / 8) * SCR_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_line,
  input  logic [CW-1:0] cmd_x0,
  input  logic [CW-1:0] cmd_y0,
  input  logic [CW-1:0] cmd_x1,
  input  logic [CW-1:0] cmd_y1,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          busy,
  output logic          done
);
  logic          rst_s1, rst_s2;
  logic          load, step, at_end, in_screen;
  logic [CW-1:0] cur_x, cur_y, end_x, end_y;
  logic [7:0]    mask;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  // a single pixel is a line whose end equals its start
  assign end_x = cmd_line ? cmd_x1 : cmd_x0;
  assign end_y = cmd_line ? cmd_y1 : cmd_y0;

  lp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s2),
    .cmd_valid (cmd_valid),
    .in_screen (in_screen),
    .at_end    (at_end),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .load      (load),
    .step      (step),
    .mem_re    (mem_re),
    .mem_we    (mem_we)
  );

  lp_stepper #(.CW(CW)) u_step (
    .clk    (clk),
    .rst_n  (rst_s2),
    .load   (load),
    .step   (step),
    .ld_x0  (cmd_x0),
    .ld_y0  (cmd_y0),
    .ld_x1  (end_x),
    .ld_y1  (end_y),
    .cur_x  (cur_x),
    .cur_y  (cur_y),
    .at_end (at_end)
  );

  lp_addr_map #(.SCR_W(SCR_W), .SCR_H(SCR_H), .CW(CW), .AW(AW)) u_map (
    .px        (cur_x),
    .py        (cur_y),
    .addr      (mem_addr),
    .mask      (mask),
    .in_screen (in_screen)
  );

  assign mem_wdata = mem_rdata | mask;

  // R6: the write-back targets the byte that was just read
  p_write_same_addr_r6: assert property (@(posedge clk) disable iff (!rst_s2)
    mem_we |-> $stable(mem_addr));
  // R6: one memory access per cycle
  p_one_access_r6: assert property (@(posedge clk) disable iff (!rst_s2)
    !(mem_re && mem_we));
  // R7: off-screen points never touch memory
  p_offscreen_quiet_r7: assert property (@(posedge clk) disable iff (!rst_s2)
    !in_screen |-> !mem_we);
endmodule

// File: tb/tb_line_plotter.sv
`timescale 1ns/1ps
module tb_line_plotter;
  localparam int W = 648;
  localparam int H = 256;
  localparam int ROWB = W / 8;
  localparam int NBYTES = ROWB * H;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_line;
  logic [10:0] cmd_x0, cmd_y0, cmd_x1, cmd_y1;
  logic [14:0] mem_addr;
  logic        mem_re, mem_we, busy, done;
  logic [7:0]  mem_rdata, mem_wdata;

  logic [7:0]  mem [NBYTES];
  logic [7:0]  exp_mem [NBYTES];
  int checks, fails, wr_cnt, rmw_err;
  logic        prev_re;
  logic [14:0] prev_addr;

  line_plotter dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_line(cmd_line), .cmd_x0(cmd_x0), .cmd_y0(cmd_y0), .cmd_x1(cmd_x1),
    .cmd_y1(cmd_y1), .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // byte memory, read data one cycle after the strobe; RMW monitor
  always @(posedge clk) begin
    if (mem_we) begin
      wr_cnt = wr_cnt + 1;
      if (!prev_re || prev_addr != mem_addr || mem_re) rmw_err = rmw_err + 1;
      mem[mem_addr] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
    prev_re   <= mem_re;
    prev_addr <= mem_addr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference walk from the requirement text
  task automatic ref_line(input int x0, input int y0, input int x1, input int y1,
                          output int nin, output int nout);
    int x, y, dx, dy, sx, sy, err, e2;
    x = x0; y = y0;
    dx = (x1 >= x0) ? x1 - x0 : x0 - x1;
    dy = (y1 >= y0) ? y1 - y0 : y0 - y1;
    sx = (x1 >= x0) ? 1 : -1;
    sy = (y1 >= y0) ? 1 : -1;
    err = dx - dy; nin = 0; nout = 0;
    forever begin
      if (x < W && y < H) begin
        exp_mem[y*ROWB + x/8] = exp_mem[y*ROWB + x/8] | (8'h80 >> (x % 8));
        nin++;
      end else nout++;
      if (x == x1 && y == y1) break;
      e2 = 2 * err;
      if (e2 >= -dy) begin err = err - dy; x = x + sx; end
      if (e2 <= dx)  begin err = err + dx; y = y + sy; end
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int i = 0; i < NBYTES; i++)
      if (mem[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, req, "framebuffer mismatching bytes", bad, 0);
    if (first >= 0)
      $display("  first bad byte %0d actual %02h expected %02h", first, mem[first], exp_mem[first]);
  endtask

  task automatic run_cmd(input bit line, input int x0, input int y0, input int x1,
                         input int y1, input string req, input bit hold);
    int nin, nout, cyc, rdy_bad;
    if (line) ref_line(x0, y0, x1, y1, nin, nout);
    else      ref_line(x0, y0, x0, y0, nin, nout);
    wr_cnt = 0; rmw_err = 0; cyc = 0; rdy_bad = 0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R8", "ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_line = line;
    cmd_x0 = 11'(x0); cmd_y0 = 11'(y0); cmd_x1 = 11'(x1); cmd_y1 = 11'(y1);
    @(negedge clk);
    if (hold) begin
      cmd_line = 1'b1; cmd_x0 = 11'd3; cmd_y0 = 11'd200; cmd_x1 = 11'd600; cmd_y1 = 11'd10;
    end else cmd_valid = 1'b0;
    while (busy) begin
      cyc++;
      if (cmd_ready) rdy_bad++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(rdy_bad == 0, "R8", "ready high while busy", rdy_bad, 0);
    chk(done == 1'b1, "R9", "done after busy", int'(done), 1);
    chk(cyc == 2*nin + nout, "R10", "busy cycles", cyc, 2*nin + nout);
    chk(wr_cnt == nin, "R7", "write count", wr_cnt, nin);
    chk(rmw_err == 0, "R6", "read/write pairing errors", rmw_err, 0);
    cmp_mem(req);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int ax, ay, bx, by;
    checks = 0; fails = 0; wr_cnt = 0; rmw_err = 0;
    void'($urandom(32'd20250));
    for (int i = 0; i < NBYTES; i++) begin
      mem[i] = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      exp_mem[i] = mem[i];
    end
    cmd_valid = 1'b0; cmd_line = 1'b0;
    cmd_x0 = '0; cmd_y0 = '0; cmd_x1 = '0; cmd_y1 = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !busy && !done && !mem_re && !mem_we, "R1", "reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !busy && !done && !mem_re && !mem_we, "R1", "after release", int'(busy), 0);

    // set pixel, far corners, ignored end fields
    run_cmd(1'b0, 0, 0, 0, 0, "R3", 1'b0);
    run_cmd(1'b0, 647, 255, 0, 0, "R3", 1'b0);
    run_cmd(1'b0, 13, 7, 500, 100, "R2", 1'b0);
    // octants and shapes
    run_cmd(1'b1, 10, 20, 90, 20, "R4", 1'b0);
    run_cmd(1'b1, 90, 40, 10, 40, "R5", 1'b0);
    run_cmd(1'b1, 300, 10, 300, 120, "R5", 1'b0);
    run_cmd(1'b1, 320, 120, 320, 10, "R5", 1'b0);
    run_cmd(1'b1, 100, 100, 160, 160, "R5", 1'b0);
    run_cmd(1'b1, 200, 160, 140, 100, "R5", 1'b0);
    run_cmd(1'b1, 400, 50, 470, 61, "R4", 1'b0);
    run_cmd(1'b1, 470, 90, 400, 70, "R5", 1'b0);
    run_cmd(1'b1, 500, 20, 511, 90, "R5", 1'b0);
    run_cmd(1'b1, 530, 90, 520, 20, "R5", 1'b0);
    run_cmd(1'b1, 50, 200, 50, 200, "R5", 1'b0);
    // off-screen handling
    run_cmd(1'b1, 630, 240, 670, 270, "R7", 1'b0);
    run_cmd(1'b0, 700, 10, 0, 0, "R7", 1'b0);
    run_cmd(1'b1, 660, 10, 700, 40, "R7", 1'b0);
    // new command held through a whole walk
    run_cmd(1'b1, 0, 250, 647, 250, "R8", 1'b1);
    // border
    run_cmd(1'b1, 0, 0, 647, 0, "R4", 1'b0);
    run_cmd(1'b1, 647, 0, 647, 255, "R4", 1'b0);
    run_cmd(1'b1, 647, 255, 0, 255, "R4", 1'b0);
    run_cmd(1'b1, 0, 255, 0, 0, "R4", 1'b0);
    // random mix
    for (int k = 0; k < 40; k++) begin
      ax = $urandom % 700; ay = $urandom % 290;
      bx = $urandom % 700; by = $urandom % 290;
      run_cmd((k % 5) != 0, ax, ay, bx, by, "R5", 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule